// File: doc/BRIEF.md
# PCM Sample Gain and Mute Stage

This stage sits in an audio output path, after decoding and before the serial converter interface. It takes a stream of stereo samples, each a signed 16-bit left and right value, and multiplies both by one 8-bit fractional gain code. A single write port loads the code. Reset loads the unity code, so decoded audio passes through unchanged until software lowers the level.

Code `c` in 0x01..0xFE scales by `(c+1)/256`. The product is shifted right arithmetically, so the result rounds toward negative infinity. Two codes are special. 0x00 forces both channels to zero (a hard mute), and 0xFF gives an exact bit-for-bit copy of the input. The gain that a sample sees is sampled together with that sample, so a gain write never splits a stereo pair or changes a sample that is already in flight. Output valid follows input valid after two clock cycles.

Top module: `pcm_scale_out`

## Requirements
- R1: After reset `out_valid` is 0, both output samples are 0, and the gain code is 0xFF, so the first sample passes through unchanged.
- R2: With gain code 0x00, both output samples are exactly 0 for any input value.
- R3: With gain code 0xFF, each output sample equals its input bit for bit, including -32768 and 32767.
- R4: With gain code c in 0x01..0xFE, each output equals floor(x*(c+1)/256), where x is the signed input sample.
- R5: The left and right samples of one input beat are scaled by the same gain code.
- R6: A sample uses the gain code that the register holds in the cycle the sample is accepted. A write in that same cycle affects only samples accepted in later cycles.
- R7: `out_valid` is high exactly two cycles after a cycle with `in_valid` high, and is low otherwise.
- R8: While `out_valid` is low, both output samples keep the value of the last valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_we | input | 1 | Write strobe for the gain code |
| gain_wdata | input | 8 | New gain code |
| in_valid | input | 1 | Input sample pair is valid this cycle |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| out_valid | output | 1 | Output sample pair is valid |
| out_left | output | 16 | Scaled left sample, signed |
| out_right | output | 16 | Scaled right sample, signed |

## Verification
The multiply is driven with the extreme values -32768 and 32767 at unity gain, which catches any path that routes unity through the multiplier or saturates. Odd negative products at half gain separate floor rounding from truncation toward zero. The smallest and largest fractional codes, 0x01 and 0xFE, expose an off-by-one in the `code+1` mapping. Each beat uses different left and right values, so a crossed or shared channel shows up. One beat is sent in the same cycle as a gain write and followed at once by a second beat; this separates a gain that is sampled with its data from one that is read late. Idle gaps between beats check the latency and that the outputs hold their value.

// File: rtl/pcm_scale_pkg.sv
package pcm_scale_pkg;
  localparam int SAMPLE_W_DEF = 16;
  localparam int GAIN_W_DEF   = 8;

  typedef enum logic [1:0] {
    GAIN_MUTE  = 2'd0,
    GAIN_FRAC  = 2'd1,
    GAIN_UNITY = 2'd2
  } gain_kind_e;

  // Sort a gain code into its three behaviours
  function automatic gain_kind_e classify_gain(input logic [GAIN_W_DEF-1:0] code);
    if (code == '0)      return GAIN_MUTE;
    else if (code == '1) return GAIN_UNITY;
    else                 return GAIN_FRAC;
  endfunction
endpackage

// File: rtl/pcm_gain_reg.sv
module pcm_gain_reg #(
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GAIN_W-1:0] wr_data,
  output logic [GAIN_W-1:0] gain_code
);
  localparam logic [GAIN_W-1:0] GAIN_RESET = '1;

  logic [GAIN_W-1:0] gain_q;
  logic              gain_load;

  assign gain_load = wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n)         gain_q <= GAIN_RESET;
    else if (gain_load) gain_q <= wr_data;
  end

  assign gain_code = gain_q;

  // R6
  gain_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> gain_code == $past(wr_data));
  // R6
  gain_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(gain_code));
endmodule

// File: rtl/pcm_scale_lane.sv
module pcm_scale_lane
  import pcm_scale_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic                       stage_v,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic        [GAIN_W-1:0]   gain_in,
  output logic signed [SAMPLE_W-1:0] sample_out
);
  localparam int MULT_W = GAIN_W + 2;           // code+1 with a zero sign bit
  localparam int PROD_W = SAMPLE_W + MULT_W;

  // Scale one sample: mute, exact bypass, or (code+1)/256 rounding down
  function automatic logic signed [SAMPLE_W-1:0] scale_sample(
    input logic signed [SAMPLE_W-1:0] x,
    input logic        [GAIN_W-1:0]   code
  );
    logic        [MULT_W-1:0] mult_u;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    mult_u  = {2'b00, code} + MULT_W'(1);
    prod    = PROD_W'(x) * $signed(PROD_W'(mult_u));
    shifted = prod >>> GAIN_W;
    case (classify_gain(code))
      GAIN_MUTE:  return '0;
      GAIN_UNITY: return x;
      default:    return shifted[SAMPLE_W-1:0];
    endcase
  endfunction

  logic signed [SAMPLE_W-1:0] s1_sample;
  logic        [GAIN_W-1:0]   s1_gain;
  logic signed [SAMPLE_W-1:0] s2_sample;
  logic signed [SAMPLE_W-1:0] scaled;

  // Stage 1: sample and its gain travel together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_sample <= '0;
      s1_gain   <= '1;
    end else if (cap_en) begin
      s1_sample <= sample_in;
      s1_gain   <= gain_in;
    end
  end

  assign scaled = scale_sample(s1_sample, s1_gain);

  // Stage 2: result register, held between beats
  always_ff @(posedge clk) begin
    if (!rst_n)       s2_sample <= '0;
    else if (stage_v) s2_sample <= scaled;
  end

  assign sample_out = s2_sample;

  // R2
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_v && s1_gain == '0) |=> sample_out == '0);
  // R3
  unity_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_v && s1_gain == '1) |=> sample_out == $past(s1_sample));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_v |=> $stable(sample_out));
  // R4
  frac_no_sign_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_v && s1_sample >= 0) |=> sample_out >= 0);
endmodule

// File: rtl/pcm_scale_out.sv
module pcm_scale_out
  import pcm_scale_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int GAIN_W   = GAIN_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gain_we,
  input  logic [GAIN_W-1:0]   gain_wdata,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  localparam int NUM_CH = 2;

  logic [GAIN_W-1:0]   gain_code;
  logic                v_stage1;
  logic                v_stage2;
  logic [SAMPLE_W-1:0] ch_in  [NUM_CH];
  logic [SAMPLE_W-1:0] ch_out [NUM_CH];

  pcm_gain_reg #(.GAIN_W(GAIN_W)) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (gain_we),
    .wr_data  (gain_wdata),
    .gain_code(gain_code)
  );

  // Shared two-stage valid pipe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_stage1 <= 1'b0;
      v_stage2 <= 1'b0;
    end else begin
      v_stage1 <= in_valid;
      v_stage2 <= v_stage1;
    end
  end

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  // Both channels get the same gain code (R5)
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    pcm_scale_lane #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (in_valid),
      .stage_v   (v_stage1),
      .sample_in (ch_in[ch]),
      .gain_in   (gain_code),
      .sample_out(ch_out[ch])
    );
  end

  assign out_valid = v_stage2;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  // R7
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |=> out_valid);
  // R7
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |=> !out_valid);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_left == '0 && out_right == '0));
endmodule

// File: tb/tb_pcm_scale_out.sv
module tb_pcm_scale_out;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gain_we = 1'b0;
  logic [7:0]  gain_wdata = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_left = '0;
  logic [15:0] in_right = '0;
  logic        out_valid;
  logic [15:0] out_left;
  logic [15:0] out_right;

  int checks = 0;
  int errors = 0;
  int cur_gain = 255;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcm_scale_out dut (
    .clk(clk), .rst_n(rst_n), .gain_we(gain_we), .gain_wdata(gain_wdata),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  // Reference model from the requirements, using floor division
  function automatic int model(input int x, input int code);
    int num;
    if (code == 0) return 0;
    if (code == 255) return x;
    num = x * (code + 1);
    if (num >= 0) return num / 256;
    return -((-num + 255) / 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_gain(input int code);
    @(negedge clk);
    gain_we = 1'b1; gain_wdata = 8'(code);
    @(negedge clk);
    gain_we = 1'b0;
    cur_gain = code;
  endtask

  // One beat with an idle cycle after it, checked at its output cycle
  task automatic send_beat(input string req, input int l, input int r);
    @(negedge clk);
    in_valid = 1'b1; in_left = 16'(l); in_right = 16'(r);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", int'(out_valid), 0);
    @(negedge clk);
    check("R7", int'(out_valid), 1);
    check(req, int'($signed(out_left)),  model(l, cur_gain));
    check(req, int'($signed(out_right)), model(r, cur_gain));
  endtask

  task automatic t_reset;
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_left), 0);
    check("R1", int'(out_right), 0);
    send_beat("R1", 12345, -4321);
  endtask

  task automatic t_unity;
    write_gain(255);
    send_beat("R3", -32768, 32767);
    send_beat("R3", -1, 1);
  endtask

  task automatic t_mute;
    write_gain(0);
    send_beat("R2", -32768, 32767);
    send_beat("R2", 1, -1);
  endtask

  task automatic t_frac;
    write_gain(127);
    send_beat("R4", 1001, -1001);
    write_gain(1);
    send_beat("R4", 300, -300);
    write_gain(254);
    send_beat("R4", 32767, -32768);
    write_gain(63);
    send_beat("R5", 20000, -7);
  endtask

  // Gain write and sample in the same cycle, next sample right behind
  task automatic t_boundary;
    write_gain(255);
    @(negedge clk);
    gain_we = 1'b1; gain_wdata = 8'd0;
    in_valid = 1'b1; in_left = 16'd1000; in_right = -16'sd2000;
    @(negedge clk);
    gain_we = 1'b0;
    in_left = 16'd3000; in_right = 16'd4000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", int'(out_valid), 1);
    check("R6", int'($signed(out_left)), 1000);
    check("R6", int'($signed(out_right)), -2000);
    @(negedge clk);
    check("R7", int'(out_valid), 1);
    check("R6", int'($signed(out_left)), 0);
    check("R6", int'($signed(out_right)), 0);
    cur_gain = 0;
  endtask

  task automatic t_hold;
    write_gain(127);
    send_beat("R8", 800, -800);
    repeat (3) begin
      @(negedge clk);
      check("R7", int'(out_valid), 0);
      check("R8", int'($signed(out_left)), 400);
      check("R8", int'($signed(out_right)), -400);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_unity;
    t_mute;
    t_frac;
    t_boundary;
    t_hold;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule